// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches one bank of up to 32 pin inputs that have already been synchronized to its clock. It turns chosen pin conditions into a single interrupt request. Each pin is configured on its own. It can react to a steady level, high or low. It can react to one edge, rising or falling. It can also react to both edges. A detected event sets a sticky status bit, and software clears that bit by writing a one to it.

A per-pin mask decides whether a pending status bit reaches the interrupt output. Software never writes the mask directly. A write-one-to-unmask port and a write-one-to-mask port change it, and these let software alter single pins without a read-modify-write. Masking stops only the interrupt output. Detection keeps running while a pin is masked, so software that wants no stale event after unmasking must clear the status bit first.

Register access uses a write strobe and a read strobe with a three-bit word index. Reads are combinational.

Top module: `pin_event_irq`

## Requirements
- R1: While reset is held, the mask reads all ones. Status, type, polarity and any-edge are all zero, and `irq` is 0.
- R2: A pin with type bit 0 uses level detection. Polarity 1 means active-high and polarity 0 means active-low. Status is set on every clock while the active level is present, so a clear has no effect until the level goes away.
- R3: A pin with type bit 1 and any-edge bit 0 uses single-edge detection. Polarity 1 sets status on a rising edge only. Polarity 0 sets status on a falling edge only.
- R4: A pin with type bit 1 and any-edge bit 1 sets status on both rising and falling edges, whatever its polarity. The any-edge bit has no effect on a level-type pin.
- R5: Writing index 1 (unmask port) clears the mask bit of every data bit that is 1. Writing index 2 (mask port) sets the mask bit of every data bit that is 1. Zero data bits leave the mask unchanged.
- R6: Register indices are: 0 mask (read-only, 1 = masked), 1 unmask port, 2 mask port, 3 status, 4 type, 5 polarity, 6 any-edge. Reads of index 1, index 2 and index 7 return 0, and `rd_data` is 0 when `rd_en` is low.
- R7: Writing index 3 clears each status bit whose data bit is 1 and leaves the other bits unchanged. If a clear and a new detection hit the same bit in the same cycle, the bit stays set.
- R8: Detection and status setting continue while a pin is masked. A status bit set while masked raises `irq` once the pin is unmasked, unless the bit was cleared first.
- R9: `irq` is a register. It goes to 1 one clock after any bit of status AND NOT mask is 1, and to 0 one clock after no such bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | W | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word index |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read word index |
| rd_data | output | W | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pins` is already synchronous to `clk` and that `wr_addr` is defined whenever `wr_en` is high. The bench meets both conditions by changing every input only on the falling clock edge. It never leaves an address floating during a write. It also holds each pin level for several clocks before a status clear, so that the edge and level it intends to test is the only event in flight.

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam logic [2:0] IX_MASK = 3'd0;
  localparam logic [2:0] IX_UNMASK = 3'd1;
  localparam logic [2:0] IX_DOMASK = 3'd2;
  localparam logic [2:0] IX_STAT = 3'd3;
  localparam logic [2:0] IX_TYPE = 3'd4;
  localparam logic [2:0] IX_POL = 3'd5;
  localparam logic [2:0] IX_ANY = 3'd6;

  logic [W-1:0] pins_q, mask_q, status_q, type_q, pol_q, any_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr;

  assign rise     = pins & ~pins_q;
  assign fall     = ~pins & pins_q;
  assign edge_hit = (any_q & (rise | fall)) | (~any_q & ((pol_q & rise) | (~pol_q & fall)));
  assign lvl_hit  = ~(pins ^ pol_q);
  assign hit      = (type_q & edge_hit) | (~type_q & lvl_hit);
  assign clr      = (wr_en && wr_addr == IX_STAT) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q   <= '0;
      mask_q   <= '1;
      status_q <= '0;
      type_q   <= '0;
      pol_q    <= '0;
      any_q    <= '0;
      irq      <= 1'b0;
    end else begin
      pins_q   <= pins;
      status_q <= (status_q & ~clr) | hit;
      irq      <= |(status_q & ~mask_q);
      if (wr_en) begin
        case (wr_addr)
          IX_UNMASK: mask_q <= mask_q & ~wr_data;
          IX_DOMASK: mask_q <= mask_q | wr_data;
          IX_TYPE:   type_q <= wr_data;
          IX_POL:    pol_q  <= wr_data;
          IX_ANY:    any_q  <= wr_data;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        IX_MASK: rd_data = mask_q;
        IX_STAT: rd_data = status_q;
        IX_TYPE: rd_data = type_q;
        IX_POL:  rd_data = pol_q;
        IX_ANY:  rd_data = any_q;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pins,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         irq,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] status_q,
  input logic [W-1:0] type_q,
  input logic [W-1:0] pol_q
);
  logic [W-1:0] clr_seen;
  assign clr_seen = (wr_en && wr_addr == 3'd3) ? wr_data : '0;

  always @(negedge clk)
    if (!rst_n) a_r1_reset: assert (&mask_q && status_q == '0 && !irq);

  a_r5_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> ((mask_q & $past(wr_data)) == '0));

  a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(status_q) & ~$past(clr_seen)) & ~status_q) == '0));

  a_r2_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(~type_q & ~(pins ^ pol_q)) & ~status_q) == '0));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq);
endmodule

bind pin_event_irq pin_event_irq_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .mask_q(mask_q), .status_q(status_q),
  .type_q(type_q), .pol_q(pol_q)
);

// File: tb/pin_event_irq_tb.sv
module pin_event_irq_tb_top;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pin_event_irq #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // fields: type, pol, any, start level, end level, expected status bit 0
  localparam logic [5:0] VEC [12] = '{
    6'b0_1_0_0_1_1, 6'b0_1_0_0_0_0, 6'b0_0_0_1_1_0, 6'b0_0_0_1_0_1,
    6'b0_1_1_0_0_0, 6'b1_1_0_0_1_1, 6'b1_1_0_1_0_0, 6'b1_0_0_1_0_1,
    6'b1_0_0_0_1_0, 6'b1_0_1_0_1_1, 6'b1_1_1_1_0_1, 6'b1_1_0_1_1_0
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] v;
    @(negedge clk);
    rd(3'd0, v); check("R1 mask", v, '1);
    rd(3'd3, v); check("R1 status", v, '0);
    rd(3'd4, v); check("R1 type", v, '0);
    check("R1 irq", {{(W-1){1'b0}}, irq}, '0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < 12; k++) begin
      wr(3'd4, {{(W-1){1'b0}}, VEC[k][5]});
      wr(3'd5, {{(W-1){1'b0}}, VEC[k][4]});
      wr(3'd6, {{(W-1){1'b0}}, VEC[k][3]});
      pins[0] = VEC[k][2];
      idle(3);
      wr(3'd3, '1);
      pins[0] = VEC[k][1];
      idle(3);
      rd(3'd3, v);
      check($sformatf("R2/R3/R4 vector %0d", k), {{(W-1){1'b0}}, v[0]}, {{(W-1){1'b0}}, VEC[k][0]});
    end

    pins = '0;
    wr(3'd4, 32'h6); wr(3'd5, 32'h6); wr(3'd6, '0);
    idle(2);
    wr(3'd3, '1);
    idle(1);
    rd(3'd3, v); check("R3 idle edges bits1-2", v & 32'h6, '0);
    pins[1] = 1'b1;
    idle(2);
    rd(3'd3, v); check("R8 status while masked", v & 32'h2, 32'h2);
    check("R8 irq while masked", {{(W-1){1'b0}}, irq}, '0);
    wr(3'd1, 32'h2);
    rd(3'd0, v); check("R5 unmask one bit", v, ~32'h2);
    @(negedge clk);
    check("R8 irq after unmask", {{(W-1){1'b0}}, irq}, 32'h1);
    wr(3'd3, 32'h2);
    @(negedge clk);
    check("R7 irq after clear", {{(W-1){1'b0}}, irq}, '0);

    @(negedge clk);
    pins[2] = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h4;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd3, v); check("R7 detect beats clear", v & 32'h4, 32'h4);
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R7 zero write keeps", v & 32'h4, 32'h4);

    wr(3'd2, 32'h2);
    rd(3'd0, v); check("R5 mask again", v, '1);

    wr(3'd5, 32'hE);
    pins[3] = 1'b1;
    idle(2);
    wr(3'd3, '1);
    rd(3'd3, v); check("R2 level clear refused", v & 32'h8, 32'h8);

    wr(3'd1, 32'h8);
    check("R9 irq not yet", {{(W-1){1'b0}}, irq}, '0);
    @(negedge clk);
    check("R9 irq one clock later", {{(W-1){1'b0}}, irq}, 32'h1);

    wr(3'd1, 32'h0);
    rd(3'd0, v); check("R5 zero unmask no effect", v, ~32'h8);
    rd(3'd1, v); check("R6 unmask port reads 0", v, '0);
    rd_addr = 3'd0; #1 v = rd_data;
    check("R6 no read strobe", v, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule